// File: doc/BRIEF.md
# Indexed Display Configuration Register Port

This block is the register front end of a display controller. Software reaches it through two 32-bit locations on a simple read/write strobe bus. The first location holds a register index. The second location reads or writes the register that the index selects. Behind the value location sit the following:
- the version handshake
- the display enable
- the requested geometry and the geometry currently in use
- a fixed colour depth, with the values derived from it
- the colour channel masks
- the capability word
- the command ring placement and the ring acceptance flag
- guest identification
- cursor state
- a bank of general-purpose scratch words

Several writes have side effects. Turning the display on or off withdraws an accepted ring configuration when the written value is zero. It also marks the current geometry as unknown (all ones) and, when the value is nonzero, latches the framebuffer size. Asking for ring acceptance checks the ring header words (the lower and upper ring bounds and the alignment bits of the two ring pointers), which the surrounding logic presents on dedicated inputs. Cursor visibility uses a set/clear/keep code instead of a plain store. The display side copies the requested geometry into the current geometry with a one-cycle pulse, and it ends a synchronisation request with another.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the index is 0, the version register reads 0x90000002, and the enable, acceptance, busy, cursor-visible and bad-access states are all 0.
- R2: A write to the index location (bus_sel=0) stores the index, and a read of the index location returns it. Every read places its data on bus_rdata in the cycle after the read strobe.
- R3: The version register (index 0) takes a written value only if the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves it unchanged.
- R4: A write to the enable register (index 1) has these effects:
  - It stores the value.
  - A zero value clears the acceptance flag.
  - The current width (index 2) and current height (index 3) read 0xFFFFFFFF afterwards.
  - A nonzero value latches the framebuffer size (index 16) as ceil(depth/8) × requested width × requested height.
- R5: Writing a nonzero value to index 20 sets the acceptance flag only if all of the following hold:
  - The lower bound, the upper bound and both pointers are multiples of 4.
  - The lower bound is at least 16.
  - The upper bound is at most 65536.
  - The upper bound is at least the lower bound plus 10240.

  If any check fails, the flag keeps its previous value. Writing zero clears it.
- R6: Writing a depth (index 6 or 7) that differs from the fixed depth clears the acceptance flag. Writing the same depth leaves the flag unchanged.
- R7: The derived registers read as follows:
  - Indices 7 and 28 read (depth+7) with bits 2:0 cleared.
  - Index 12 reads ceil(depth/8) × requested width.
  - Index 4 reads 2360 and index 5 reads 1770.
  - For depth 24, index 9 (red mask) reads 0x00FF0000.
- R8: Writing 1 to index 27 makes the cursor visible and writing 0 hides it. Writing 2 or 3 leaves visibility unchanged.
- R9: The capability word (index 17) always has bits 0 and 1 set. It has bits 5, 6 and 7 set exactly when cursor_hw is high.
- R10: Indices 1792 to 1792+SCR_N-1 are read/write scratch words.
- R11: Reads of the palette range (1024 to 1791) return 0 and do not raise bad_access. An access to an index outside every defined range reads 0, changes nothing, and sets bad_access, which stays set until reset.
- R12: A write to index 21 sets busy, which reads as 1 at index 21 or 22 and drives sync_busy. A sync_done pulse clears busy.
- R13: A size_apply pulse copies the requested width and height into the current width and height.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | 0 selects the index location, 1 selects the value location |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ring_min | input | 32 | Ring header lower bound (byte offset) |
| ring_max | input | 32 | Ring header upper bound (byte offset) |
| ring_ptr_lsb | input | 4 | Bits 1:0 of the next-command pointer (3:2) and of the stop pointer (1:0) |
| cursor_hw | input | 1 | Hardware cursor present |
| size_apply | input | 1 | Pulse: take requested geometry as current |
| sync_done | input | 1 | Pulse: synchronisation finished |
| disp_enable | output | 1 | Enable register is nonzero |
| cfg_valid | output | 1 | Ring configuration accepted |
| sync_busy | output | 1 | Synchronisation pending |
| bad_access | output | 1 | Sticky undefined-index access flag |

## Verification
The hardest situation to reach is a rejected ring acceptance while the flag is already set. A rejected request and an unchanged flag look the same unless the flag was 1 beforehand. To create that state, the stimulus first accepts a valid header. It then changes one header input at a time and makes a new nonzero request for each change. The changes are:
- a misaligned pointer
- a lower bound of 12
- an upper bound just past 64 KiB
- a span 4 bytes short of 10240

After each request the bench reads index 20. Each exact-limit header must also be accepted from a cleared flag, so that a rule off by one is caught in both directions.

// File: rtl/cfg_index_port_pkg.sv
package cfg_index_port_pkg;

   localparam int IX_ID        = 0;
   localparam int IX_ENABLE    = 1;
   localparam int IX_WIDTH     = 2;
   localparam int IX_HEIGHT    = 3;
   localparam int IX_MAX_W     = 4;
   localparam int IX_MAX_H     = 5;
   localparam int IX_DEPTH     = 6;
   localparam int IX_BPP       = 7;
   localparam int IX_PSEUDO    = 8;
   localparam int IX_RED       = 9;
   localparam int IX_GREEN     = 10;
   localparam int IX_BLUE      = 11;
   localparam int IX_LINE      = 12;
   localparam int IX_FB_START  = 13;
   localparam int IX_FB_OFS    = 14;
   localparam int IX_VRAM      = 15;
   localparam int IX_FB_SIZE   = 16;
   localparam int IX_CAPS      = 17;
   localparam int IX_RING_ADR  = 18;
   localparam int IX_RING_LEN  = 19;
   localparam int IX_CFG       = 20;
   localparam int IX_SYNC      = 21;
   localparam int IX_BUSY      = 22;
   localparam int IX_GUEST     = 23;
   localparam int IX_CUR_ID    = 24;
   localparam int IX_CUR_X     = 25;
   localparam int IX_CUR_Y     = 26;
   localparam int IX_CUR_ON    = 27;
   localparam int IX_HOST_BPP  = 28;
   localparam int IX_SCR_CNT   = 29;
   localparam int IX_RSVD_A    = 30;
   localparam int IX_RSVD_B    = 31;
   localparam int IX_RSVD_C    = 32;
   localparam int PAL_FIRST    = 1024;
   localparam int PAL_LAST     = 1791;
   localparam int SCR_BASE     = 1792;

   localparam logic [31:0] VER_0 = 32'h9000_0000;
   localparam logic [31:0] VER_1 = 32'h9000_0001;
   localparam logic [31:0] VER_2 = 32'h9000_0002;

   localparam logic [31:0] CAP_FIXED  = 32'h0000_0003;
   localparam logic [31:0] CAP_CURSOR = 32'h0000_00E0;

   typedef struct packed {
      logic [31:0] red;
      logic [31:0] green;
      logic [31:0] blue;
   } chan_masks_t;

   function automatic chan_masks_t masks_for(input int depth);
      chan_masks_t m;
      case (depth)
         8:       m = '{32'h07, 32'h38, 32'hC0};
         15:      m = '{32'h1F, 32'h3E0, 32'h7C00};
         16:      m = '{32'h1F, 32'h7E0, 32'hF800};
         default: m = '{32'h00FF_0000, 32'h0000_FF00, 32'h0000_00FF};
      endcase
      return m;
   endfunction

   function automatic logic [31:0] rounded_bits(input int depth);
      return 32'((depth + 7) & ~7);
   endfunction

endpackage

// File: rtl/cfg_ring_check.sv
module cfg_ring_check #(
   parameter logic [31:0] HDR_BYTES  = 32'd16,
   parameter logic [31:0] RING_BYTES = 32'h0001_0000,
   parameter int          MIN_SPAN   = 10240
) (
   input  logic [31:0] lo_bound,
   input  logic [31:0] hi_bound,
   input  logic [3:0]  ptr_lsb,
   output logic        hdr_ok
);
   localparam int NWORDS = 4;

   logic [2*NWORDS-1:0] lsb_all;
   logic [NWORDS-1:0]   word_aligned;
   logic                range_ok;

   assign lsb_all = {ptr_lsb, hi_bound[1:0], lo_bound[1:0]};

   for (genvar g = 0; g < NWORDS; g++) begin : g_align
      assign word_aligned[g] = (lsb_all[2*g +: 2] == 2'b00);
   end

   always_comb begin
      range_ok = (lo_bound >= HDR_BYTES) &&
                 (hi_bound <= RING_BYTES) &&
                 ({1'b0, hi_bound} >= ({1'b0, lo_bound} + 33'(MIN_SPAN)));
   end

   assign hdr_ok = (&word_aligned) && range_ok;

endmodule

// File: rtl/cfg_geom_calc.sv
module cfg_geom_calc #(
   parameter int DEPTH = 24,
   parameter int DIM_W = 16
) (
   input  logic [DIM_W-1:0] req_w,
   input  logic [DIM_W-1:0] req_h,
   output logic [31:0]      line_bytes,
   output logic [31:0]      frame_bytes
);
   localparam int BYPP = (DEPTH + 7) / 8;

   assign line_bytes  = 32'(BYPP) * 32'(req_w);
   assign frame_bytes = line_bytes * 32'(req_h);

endmodule

// File: rtl/cfg_scratch_bank.sv
module cfg_scratch_bank #(
   parameter int N  = 16,
   parameter int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);
   logic [31:0] word_q [N];

   for (genvar e = 0; e < N; e++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        word_q[e] <= '0;
         else if (we && (32'(addr) == e))   word_q[e] <= wdata;
      end
   end

   assign rdata = word_q[addr];

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_index_port_pkg::*;
#(
   parameter int          IDX_W      = 16,
   parameter int          DEPTH      = 24,
   parameter int          DIM_W      = 16,
   parameter int          SCR_N      = 16,
   parameter int          MAX_W      = 2360,
   parameter int          MAX_H      = 1770,
   parameter logic [31:0] FB_BASE    = 32'hE000_0000,
   parameter logic [31:0] VRAM_BYTES = 32'h0080_0000,
   parameter logic [31:0] RING_BYTES = 32'h0001_0000,
   parameter logic [31:0] HDR_BYTES  = 32'd16,
   parameter int          MIN_SPAN   = 10240
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic        bus_sel,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic [31:0] ring_min,
   input  logic [31:0] ring_max,
   input  logic [3:0]  ring_ptr_lsb,
   input  logic        cursor_hw,
   input  logic        size_apply,
   input  logic        sync_done,
   output logic        disp_enable,
   output logic        cfg_valid,
   output logic        sync_busy,
   output logic        bad_access
);
   localparam int          SCR_AW    = $clog2(SCR_N);
   localparam int          SCR_END   = SCR_BASE + SCR_N;
   localparam chan_masks_t MASKS     = masks_for(DEPTH);
   localparam logic [31:0] BITS_RND  = rounded_bits(DEPTH);
   localparam logic [31:0] RING_ADDR = FB_BASE + VRAM_BYTES - RING_BYTES;
   localparam logic [31:0] VRAM_FREE = VRAM_BYTES - RING_BYTES;

   // elaboration-time parameter checks
   if (!(DEPTH == 8 || DEPTH == 15 || DEPTH == 16 || DEPTH == 24 || DEPTH == 32))
   begin : g_bad_depth
      $error("cfg_index_port: DEPTH must be 8, 15, 16, 24 or 32");
   end
   if (SCR_N < 2 || SCR_N > 1024) begin : g_bad_scr
      $error("cfg_index_port: SCR_N must lie in 2..1024");
   end
   if (IDX_W < 11 || IDX_W > 32 || SCR_END > (64'd1 << IDX_W)) begin : g_bad_idx
      $error("cfg_index_port: IDX_W too narrow for the scratch range");
   end
   if (DIM_W < 1 || DIM_W > 32) begin : g_bad_dim
      $error("cfg_index_port: DIM_W must lie in 1..32");
   end
   if (VRAM_BYTES <= RING_BYTES) begin : g_bad_vram
      $error("cfg_index_port: VRAM_BYTES must exceed RING_BYTES");
   end

   logic [IDX_W-1:0] idx_q;
   logic [31:0]      idx_ext;
   logic [31:0]      id_q, enable_q, guest_q;
   logic [31:0]      cur_w_q, cur_h_q, fb_size_q;
   logic [DIM_W-1:0] req_w_q, req_h_q;
   logic [31:0]      cur_id_q, cur_x_q, cur_y_q;
   logic             cur_on_q, cfg_q, busy_q, bad_q;
   logic [31:0]      rdata_q;

   logic [31:0]      line_bytes, frame_bytes, scr_rdata, rd_val;
   logic             ring_ok, scr_hit, pal_hit, known;
   logic [SCR_AW-1:0] scr_addr;
   logic             wr_val, wr_idx;

   assign idx_ext  = 32'(idx_q);
   assign wr_val   = bus_wr && bus_sel;
   assign wr_idx   = bus_wr && !bus_sel;
   assign scr_hit  = (idx_ext >= 32'(SCR_BASE)) && (idx_ext < 32'(SCR_END));
   assign pal_hit  = (idx_ext >= 32'(PAL_FIRST)) && (idx_ext <= 32'(PAL_LAST));
   assign scr_addr = SCR_AW'(idx_ext - 32'(SCR_BASE));

   cfg_ring_check #(
      .HDR_BYTES (HDR_BYTES),
      .RING_BYTES(RING_BYTES),
      .MIN_SPAN  (MIN_SPAN)
   ) u_ring_check (
      .lo_bound(ring_min),
      .hi_bound(ring_max),
      .ptr_lsb (ring_ptr_lsb),
      .hdr_ok  (ring_ok)
   );

   cfg_geom_calc #(
      .DEPTH(DEPTH),
      .DIM_W(DIM_W)
   ) u_geom (
      .req_w      (req_w_q),
      .req_h      (req_h_q),
      .line_bytes (line_bytes),
      .frame_bytes(frame_bytes)
   );

   cfg_scratch_bank #(
      .N (SCR_N),
      .AW(SCR_AW)
   ) u_scratch (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_val && scr_hit),
      .addr (scr_addr),
      .wdata(bus_wdata),
      .rdata(scr_rdata)
   );

   // value-location read decode
   always_comb begin
      rd_val = '0;
      known  = 1'b1;
      case (idx_ext)
         IX_ID:                            rd_val = id_q;
         IX_ENABLE:                        rd_val = enable_q;
         IX_WIDTH:                         rd_val = cur_w_q;
         IX_HEIGHT:                        rd_val = cur_h_q;
         IX_MAX_W:                         rd_val = 32'(MAX_W);
         IX_MAX_H:                         rd_val = 32'(MAX_H);
         IX_DEPTH:                         rd_val = 32'(DEPTH);
         IX_BPP, IX_HOST_BPP:              rd_val = BITS_RND;
         IX_RED:                           rd_val = MASKS.red;
         IX_GREEN:                         rd_val = MASKS.green;
         IX_BLUE:                          rd_val = MASKS.blue;
         IX_LINE:                          rd_val = line_bytes;
         IX_FB_START:                      rd_val = FB_BASE;
         IX_VRAM:                          rd_val = VRAM_FREE;
         IX_FB_SIZE:                       rd_val = fb_size_q;
         IX_CAPS:                          rd_val = CAP_FIXED | (cursor_hw ? CAP_CURSOR : 32'h0);
         IX_RING_ADR:                      rd_val = RING_ADDR;
         IX_RING_LEN:                      rd_val = RING_BYTES;
         IX_CFG:                           rd_val = 32'(cfg_q);
         IX_SYNC, IX_BUSY:                 rd_val = 32'(busy_q);
         IX_GUEST:                         rd_val = guest_q;
         IX_CUR_ID:                        rd_val = cur_id_q;
         IX_CUR_X:                         rd_val = cur_x_q;
         IX_CUR_Y:                         rd_val = cur_y_q;
         IX_CUR_ON:                        rd_val = 32'(cur_on_q);
         IX_SCR_CNT:                       rd_val = 32'(SCR_N);
         IX_PSEUDO, IX_FB_OFS,
         IX_RSVD_A, IX_RSVD_B, IX_RSVD_C:  rd_val = '0;
         default: begin
            if (scr_hit)      rd_val = scr_rdata;
            else if (pal_hit) rd_val = '0;
            else              known  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= '0;
         id_q      <= VER_2;
         enable_q  <= '0;
         guest_q   <= '0;
         cur_w_q   <= '0;
         cur_h_q   <= '0;
         fb_size_q <= '0;
         req_w_q   <= '0;
         req_h_q   <= '0;
         cur_id_q  <= '0;
         cur_x_q   <= '0;
         cur_y_q   <= '0;
         cur_on_q  <= 1'b0;
         cfg_q     <= 1'b0;
         busy_q    <= 1'b0;
         bad_q     <= 1'b0;
         rdata_q   <= '0;
      end else begin
         if (bus_rd) rdata_q <= bus_sel ? rd_val : idx_ext;
         if ((bus_rd || bus_wr) && bus_sel && !known) bad_q <= 1'b1;
         if (sync_done) busy_q <= 1'b0;
         if (size_apply) begin
            cur_w_q <= 32'(req_w_q);
            cur_h_q <= 32'(req_h_q);
         end
         if (wr_idx) idx_q <= bus_wdata[IDX_W-1:0];
         if (wr_val) begin
            case (idx_ext)
               IX_ID:
                  if (bus_wdata == VER_0 || bus_wdata == VER_1 || bus_wdata == VER_2)
                     id_q <= bus_wdata;
               IX_ENABLE: begin
                  enable_q <= bus_wdata;
                  cur_w_q  <= '1;
                  cur_h_q  <= '1;
                  if (bus_wdata == '0) cfg_q     <= 1'b0;
                  else                 fb_size_q <= frame_bytes;
               end
               IX_WIDTH:  req_w_q <= bus_wdata[DIM_W-1:0];
               IX_HEIGHT: req_h_q <= bus_wdata[DIM_W-1:0];
               IX_DEPTH, IX_BPP:
                  if (bus_wdata != 32'(DEPTH)) cfg_q <= 1'b0;
               IX_CFG:
                  if (bus_wdata == '0) cfg_q <= 1'b0;
                  else if (ring_ok)    cfg_q <= 1'b1;
               IX_SYNC:   busy_q   <= 1'b1;
               IX_GUEST:  guest_q  <= bus_wdata;
               IX_CUR_ID: cur_id_q <= bus_wdata;
               IX_CUR_X:  cur_x_q  <= bus_wdata;
               IX_CUR_Y:  cur_y_q  <= bus_wdata;
               IX_CUR_ON:
                  if (bus_wdata == 32'd1)      cur_on_q <= 1'b1;
                  else if (bus_wdata == 32'd0) cur_on_q <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   assign bus_rdata   = rdata_q;
   assign disp_enable = (enable_q != '0);
   assign cfg_valid   = cfg_q;
   assign sync_busy   = busy_q;
   assign bad_access  = bad_q;

   // ---------------- assertions ----------------
   assert_id_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (id_q == VER_0) || (id_q == VER_1) || (id_q == VER_2));

   assert_enable_zero_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_val && idx_ext == IX_ENABLE && bus_wdata == '0) |=> !cfg_q);

   assert_cfg_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_q) |-> $past(wr_val && idx_ext == IX_CFG && ring_ok));

   assert_cursor_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_val && idx_ext == IX_CUR_ON && bus_wdata > 32'd1) |=> $stable(cur_on_q));

   assert_bad_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q |=> bad_q);

   assert_sync_sets_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_val && idx_ext == IX_SYNC) |=> busy_q);

   assert_apply_width_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (size_apply && !wr_val) |=> (cur_w_q == 32'($past(req_w_q))));

endmodule

// File: tb/cfg_index_port_bench.sv
`timescale 1ns/1ps
module cfg_index_port_bench;
   localparam int SCR_N = 16;
   localparam int NV    = 38;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] ring_min = 32'd16, ring_max = 32'h0001_0000;
   logic [3:0]  ring_ptr_lsb = 4'h0;
   logic        cursor_hw = 1'b1, size_apply = 1'b0, sync_done = 1'b0;
   logic        disp_enable, cfg_valid, sync_busy, bad_access;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   cfg_index_port u_cfg_index_port (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ring_min(ring_min), .ring_max(ring_max), .ring_ptr_lsb(ring_ptr_lsb),
      .cursor_hw(cursor_hw), .size_apply(size_apply), .sync_done(sync_done),
      .disp_enable(disp_enable), .cfg_valid(cfg_valid),
      .sync_busy(sync_busy), .bad_access(bad_access)
   );

   // {write, req, index, data-or-expected}
   localparam logic [52:0] VEC [NV] = '{
      {1'b0, 4'd1,  16'd0,    32'h9000_0002},  // R1 version after reset
      {1'b1, 4'd3,  16'd0,    32'h1234_5678},  // R3 illegal version
      {1'b0, 4'd3,  16'd0,    32'h9000_0002},
      {1'b1, 4'd3,  16'd0,    32'h9000_0000},  // R3 legal version
      {1'b0, 4'd3,  16'd0,    32'h9000_0000},
      {1'b0, 4'd7,  16'd4,    32'd2360},       // R7 limits
      {1'b0, 4'd7,  16'd5,    32'd1770},
      {1'b0, 4'd7,  16'd7,    32'd24},
      {1'b0, 4'd7,  16'd28,   32'd24},
      {1'b1, 4'd7,  16'd2,    32'd640},
      {1'b0, 4'd7,  16'd12,   32'd1920},       // R7 bytes per line
      {1'b1, 4'd4,  16'd3,    32'd480},        // R4 enable side effects
      {1'b1, 4'd4,  16'd1,    32'd1},
      {1'b0, 4'd4,  16'd1,    32'd1},
      {1'b0, 4'd4,  16'd2,    32'hFFFF_FFFF},
      {1'b0, 4'd4,  16'd3,    32'hFFFF_FFFF},
      {1'b0, 4'd4,  16'd16,   32'd921600},
      {1'b0, 4'd9,  16'd17,   32'h0000_00E3},  // R9 caps with cursor
      {1'b1, 4'd5,  16'd20,   32'd1},          // R5 accept
      {1'b0, 4'd5,  16'd20,   32'd1},
      {1'b1, 4'd6,  16'd7,    32'd24},         // R6 same depth
      {1'b0, 4'd6,  16'd20,   32'd1},
      {1'b1, 4'd6,  16'd6,    32'd16},         // R6 other depth
      {1'b0, 4'd6,  16'd20,   32'd0},
      {1'b1, 4'd8,  16'd27,   32'd1},          // R8 cursor codes
      {1'b0, 4'd8,  16'd27,   32'd1},
      {1'b1, 4'd8,  16'd27,   32'd2},
      {1'b0, 4'd8,  16'd27,   32'd1},
      {1'b1, 4'd8,  16'd27,   32'd0},
      {1'b0, 4'd8,  16'd27,   32'd0},
      {1'b1, 4'd8,  16'd27,   32'd3},
      {1'b0, 4'd8,  16'd27,   32'd0},
      {1'b1, 4'd10, 16'd1792, 32'hDEAD_BEEF},  // R10 scratch
      {1'b1, 4'd10, 16'd1807, 32'h0000_0055},
      {1'b0, 4'd10, 16'd1792, 32'hDEAD_BEEF},
      {1'b0, 4'd10, 16'd1807, 32'h0000_0055},
      {1'b0, 4'd11, 16'd1024, 32'd0},          // R11 palette
      {1'b0, 4'd7,  16'd9,    32'h00FF_0000}   // R7 red mask
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic sel, output logic [31:0] d);
      @(negedge clk);
      bus_sel = sel; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_reg(input int idx, input logic [31:0] d);
      bus_write(1'b0, 32'(idx));
      bus_write(1'b1, d);
   endtask

   task automatic get_reg(input int idx, output logic [31:0] d);
      bus_write(1'b0, 32'(idx));
      bus_read(1'b1, d);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic try_cfg(input string req, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [3:0] lsb, input logic [31:0] exp);
      logic [31:0] r;
      ring_min = lo; ring_max = hi; ring_ptr_lsb = lsb;
      set_reg(20, 32'd1);
      get_reg(20, r);
      chk(req, r, exp);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state at the ports
      @(negedge clk);
      chk("R1 flags", {28'd0, disp_enable, cfg_valid, sync_busy, bad_access}, 32'd0);
      bus_read(1'b0, r);
      chk("R1 index", r, 32'd0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][52]) set_reg(int'(VEC[i][47:32]), VEC[i][31:0]);
         else begin
            get_reg(int'(VEC[i][47:32]), r);
            chk($sformatf("R%0d row %0d", VEC[i][51:48], i), r, VEC[i][31:0]);
         end
      end
      chk("R11 palette no flag", 32'(bad_access), 32'd0);

      // R2 index location round trip
      bus_write(1'b0, 32'h0000_1234);
      bus_read(1'b0, r);
      chk("R2", r, 32'h0000_1234);

      // R11 undefined index
      get_reg(40, r);
      chk("R11 read zero", r, 32'd0);
      chk("R11 flag set", 32'(bad_access), 32'd1);
      set_reg(1808, 32'hAAAA_5555);
      get_reg(1808, r);
      chk("R11 write ignored", r, 32'd0);
      get_reg(0, r);
      chk("R11 sticky", 32'(bad_access), 32'd1);

      // R5 acceptance boundaries
      do_reset();
      try_cfg("R5 misaligned ptr", 32'd16, 32'h0001_0000, 4'b0100, 32'd0);
      try_cfg("R5 exact limits", 32'd16, 32'd16 + 32'd10240, 4'h0, 32'd1);
      try_cfg("R5 short span keeps", 32'd16, 32'd16 + 32'd10236, 4'h0, 32'd1);
      try_cfg("R5 low min keeps", 32'd12, 32'h0001_0000, 4'h0, 32'd1);
      try_cfg("R5 high max keeps", 32'd16, 32'h0001_0004, 4'h0, 32'd1);
      try_cfg("R5 bad stop keeps", 32'd16, 32'h0001_0000, 4'b0010, 32'd1);
      set_reg(20, 32'd0);
      get_reg(20, r);
      chk("R5 zero clears", r, 32'd0);
      try_cfg("R5 short span", 32'd16, 32'd16 + 32'd10236, 4'h0, 32'd0);
      try_cfg("R5 min 12", 32'd12, 32'd12 + 32'd20000, 4'h0, 32'd0);
      try_cfg("R5 max beyond", 32'd16, 32'h0001_0004, 4'h0, 32'd0);
      try_cfg("R5 max at ring end", 32'd16, 32'h0001_0000, 4'h0, 32'd1);
      chk("R5 port", 32'(cfg_valid), 32'd1);

      // R4 zero enable clears acceptance and disables
      set_reg(1, 32'd0);
      chk("R4 cfg cleared", 32'(cfg_valid), 32'd0);
      chk("R4 disabled", 32'(disp_enable), 32'd0);
      get_reg(16, r);
      chk("R4 size unchanged on disable", r, 32'd0);

      // R13 geometry apply
      set_reg(2, 32'd800);
      set_reg(3, 32'd600);
      pulse(size_apply);
      get_reg(2, r);
      chk("R13 width", r, 32'd800);
      get_reg(3, r);
      chk("R13 height", r, 32'd600);

      // R12 sync handshake
      set_reg(21, 32'd1);
      chk("R12 busy port", 32'(sync_busy), 32'd1);
      get_reg(22, r);
      chk("R12 busy read", r, 32'd1);
      pulse(sync_done);
      get_reg(21, r);
      chk("R12 cleared", r, 32'd0);

      // R9 without cursor
      cursor_hw = 1'b0;
      get_reg(17, r);
      chk("R9 no cursor", r, 32'h0000_0003);

      done = 1'b1;
      finish_run();
   end
endmodule